// File: doc/BRIEF.md
# Phase-Offset Synchronized Clock Divider

This block divides a fast input clock by an integer ratio. The ratio is built from a programmable high-phase length and a programmable low-phase length, each from 1 to 16 fast-clock cycles. A synchronous sync strobe forces the divided output to a selectable starting level and restarts the divider. Once the strobe falls, the divider waits a programmable number of extra fast-clock cycles before it starts counting its first segment.

Several copies share one fast clock and one sync strobe. Each copy can have its own delay setting, so their outputs are skewed from one another by whole fast-clock periods. The 4-bit delay and the start-level bit form a 5-bit setting with 32 values. Configuration is captured only while the strobe is high, so changing the inputs while the divider runs has no effect.

Top module: `phase_sync_divider`

## Requirements
- R1: While `rst_n` is low, `clk_out` is 0.
- R2: On every rising clock edge that samples `sync` high, `clk_out` takes the value of `start_hi` and keeps it while `sync` stays high.
- R3: Let k count the rising edges after the last edge that sampled `sync` high, with k = 0 at that edge. Let P be the `phase_ofs` value and A be the length of the start-level segment. `clk_out` then keeps the start level for k < P + A and first toggles at k = P + A.
- R4: A high segment lasts `hi_len`+1 cycles and a low segment lasts `lo_len`+1 cycles (field value n means n+1 cycles, 1 to 16). The output period is the sum of the two, from 2 to 32 cycles. Equal fields give 50% duty.
- R5: Two instances that share the clock, the sync strobe, the segment lengths and the start level, but whose offsets differ by D, have every output edge D cycles apart. An offset equal to the total divide gives the same waveform as offset 0 from k = P onward.
- R6: Changes to `hi_len`, `lo_len`, `phase_ofs` and `start_hi` while `sync` is low do not change `clk_out` until the next sync.
- R7: With `start_hi` = 1, the output holds high from the sync and the first segment uses the high length. The 5-bit setting {`start_hi`, `phase_ofs`} therefore selects one of 32 distinct behaviours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Synchronous restart strobe, active high |
| hi_len | input | CNT_W | High segment length minus one |
| lo_len | input | CNT_W | Low segment length minus one |
| phase_ofs | input | PH_W | Extra delay before counting starts after sync |
| start_hi | input | 1 | Output level from sync until the first toggle |
| clk_out | output | 1 | Divided clock |

## Verification
A delay counter that is loaded or decremented wrongly shifts the first toggle after sync. That shift shows on `clk_out` within P + 17 cycles of the strobe falling, and it appears as a constant edge skew between instances. A segment counter with the wrong terminal count changes the duty or the period within a single output period. A configuration register that captures outside sync shows up as a changed waveform a few cycles after the inputs are scrambled mid-run.

// File: rtl/phsdiv_pkg.sv
package phsdiv_pkg;
  localparam int MAXW = 8;

  // Terminal count of the segment the output is currently in.
  function automatic logic [MAXW-1:0] seg_last(input logic level,
                                                input logic [MAXW-1:0] hi_f,
                                                input logic [MAXW-1:0] lo_f);
    return level ? hi_f : lo_f;
  endfunction
endpackage

// File: rtl/phsdiv_cfg.sv
module phsdiv_cfg #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic [CNT_W-1:0] hi_in,
  input  logic [CNT_W-1:0] lo_in,
  output logic [CNT_W-1:0] hi_q,
  output logic [CNT_W-1:0] lo_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (sync) begin
      hi_q <= hi_in;
      lo_q <= lo_in;
    end
  end
endmodule

// File: rtl/phsdiv_phase.sv
module phsdiv_phase #(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync,
  input  logic [PH_W-1:0] phase_in,
  output logic            delay_done
);
  logic [PH_W-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wait_q <= '0;
    else if (sync)           wait_q <= phase_in;
    else if (wait_q != '0)   wait_q <= wait_q - 1'b1;
  end

  assign delay_done = (wait_q == '0);
endmodule

// File: rtl/phsdiv_seg.sv
module phsdiv_seg
  import phsdiv_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic             start_in,
  input  logic             delay_done,
  input  logic [CNT_W-1:0] hi_q,
  input  logic [CNT_W-1:0] lo_q,
  output logic             toggle_evt,
  output logic             level_q
);
  logic [CNT_W-1:0] cnt_q;
  logic [MAXW-1:0]  last_w;
  logic [CNT_W-1:0] last_c;

  assign last_w     = seg_last(level_q, MAXW'(hi_q), MAXW'(lo_q));
  assign last_c     = last_w[CNT_W-1:0];
  assign toggle_evt = !sync && delay_done && (cnt_q == last_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (sync) begin
      cnt_q   <= '0;
      level_q <= start_in;
    end else if (toggle_evt) begin
      cnt_q   <= '0;
      level_q <= ~level_q;
    end else if (delay_done) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/phase_sync_divider.sv
module phase_sync_divider #(
  parameter int CNT_W = 4,
  parameter int PH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic [CNT_W-1:0] hi_len,
  input  logic [CNT_W-1:0] lo_len,
  input  logic [PH_W-1:0]  phase_ofs,
  input  logic             start_hi,
  output logic             clk_out
);
  logic [CNT_W-1:0] hi_q;
  logic [CNT_W-1:0] lo_q;
  logic             delay_done;
  logic             toggle_evt;

  phsdiv_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .sync(sync),
    .hi_in(hi_len), .lo_in(lo_len), .hi_q(hi_q), .lo_q(lo_q)
  );

  phsdiv_phase #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .sync(sync),
    .phase_in(phase_ofs), .delay_done(delay_done)
  );

  phsdiv_seg #(.CNT_W(CNT_W)) u_seg (
    .clk(clk), .rst_n(rst_n), .sync(sync), .start_in(start_hi),
    .delay_done(delay_done), .hi_q(hi_q), .lo_q(lo_q),
    .toggle_evt(toggle_evt), .level_q(clk_out)
  );
endmodule

// File: rtl/phsdiv_checker.sv
module phsdiv_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync,
  input logic             start_hi,
  input logic             clk_out,
  input logic             delay_done,
  input logic             toggle_evt,
  input logic [CNT_W-1:0] hi_q,
  input logic [CNT_W-1:0] lo_q
);
  always_comb begin
    if (!rst_n) p_reset_low_r1: assert (clk_out == 1'b0);
  end

  p_sync_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> clk_out == $past(start_hi));

  p_hold_in_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && !delay_done) |=> $stable(clk_out));

  p_edge_only_on_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && !toggle_evt) |=> $stable(clk_out));

  p_evt_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_evt |=> clk_out != $past(clk_out));

  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

bind phase_sync_divider phsdiv_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync(sync), .start_hi(start_hi),
  .clk_out(clk_out), .delay_done(delay_done), .toggle_evt(toggle_evt),
  .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/phase_sync_divider_tb.sv
module phase_sync_divider_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync = 1'b0;
  logic [3:0] hi_f = '0, lo_f = '0;
  logic [3:0] ph [4];
  logic       st [4];
  logic [3:0] outs;
  int vecs = 0, errs = 0;
  bit done = 0;

  // model configuration captured at sync
  int m_h, m_l, m_p [4];
  logic m_s [4];
  int first_rise [4];
  logic prev [4];

  always #2 clk = ~clk;

  for (genvar i = 0; i < 4; i++) begin : g_dut
    phase_sync_divider u_dut (
      .clk(clk), .rst_n(rst_n), .sync(sync), .hi_len(hi_f), .lo_len(lo_f),
      .phase_ofs(ph[i]), .start_hi(st[i]), .clk_out(outs[i])
    );
  end

  function automatic logic exp_level(int k, int h, int l, int p, logic s);
    int a, b, t, u;
    a = s ? h : l;
    b = s ? l : h;
    if (k < p) return s;
    t = k - p;
    if (t < a) return s;
    u = (t - a) % (a + b);
    return (u < b) ? ~s : s;
  endfunction

  task automatic check(string req, logic act, logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_sync(int ncyc);
    @(negedge clk);
    sync = 1'b1;
    m_h = int'(hi_f) + 1;
    m_l = int'(lo_f) + 1;
    for (int i = 0; i < 4; i++) begin
      m_p[i] = int'(ph[i]);
      m_s[i] = st[i];
    end
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) check("R2", outs[i], m_s[i]);
    end
    sync = 1'b0;
  endtask

  // scramble_at < 0 disables mid-run input changes (R6)
  task automatic run(int ncyc, int scramble_at);
    for (int i = 0; i < 4; i++) begin
      first_rise[i] = -1;
      prev[i] = m_s[i];
    end
    for (int k = 0; k < ncyc; k++) begin
      for (int i = 0; i < 4; i++) begin
        check(k == scramble_at + 2 ? "R6" : (m_s[i] ? "R7" : "R3/R4"),
              outs[i], exp_level(k, m_h, m_l, m_p[i], m_s[i]));
        if (outs[i] && !prev[i] && first_rise[i] < 0) first_rise[i] = k;
        prev[i] = outs[i];
      end
      if (k == scramble_at) begin
        hi_f = 4'($urandom);
        lo_f = 4'($urandom);
        for (int i = 0; i < 4; i++) begin
          ph[i] = 4'($urandom);
          st[i] = 1'($urandom);
        end
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4; i++) begin
      ph[i] = '0;
      st[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) check("R1", outs[i], 1'b0);
    rst_n = 1'b1;

    // R5: divide by 4, 50% duty, offsets 0..3 give quarter-period skew
    hi_f = 4'd1; lo_f = 4'd1;
    for (int i = 0; i < 4; i++) ph[i] = 4'(i);
    do_sync(2);
    run(40, -1);
    for (int i = 1; i < 4; i++) begin
      vecs++;
      if (first_rise[i] - first_rise[0] != i) begin
        errs++;
        $display("FAIL R5: skew %0d expected %0d", first_rise[i] - first_rise[0], i);
      end
    end

    // R5: offset equal to the divide matches offset 0 after the delay
    ph[0] = 4'd0; ph[1] = 4'd4; ph[2] = 4'd8; ph[3] = 4'd2;
    do_sync(1);
    for (int k = 0; k < 30; k++) begin
      if (k >= 4) check("R5", outs[1], outs[0]);
      if (k >= 8) check("R5", outs[2], outs[0]);
      @(negedge clk);
    end

    // corners: longest segments, max offset, start high (R7), shortest segments
    hi_f = 4'd15; lo_f = 4'd15;
    ph[0] = 4'd15; st[0] = 1'b1; ph[1] = 4'd0; st[1] = 1'b1;
    ph[2] = 4'd15; st[2] = 1'b0; ph[3] = 4'd7; st[3] = 1'b0;
    do_sync(3);
    run(90, -1);
    hi_f = 4'd0; lo_f = 4'd0;
    do_sync(1);
    run(30, -1);
    hi_f = 4'd2; lo_f = 4'd9;
    do_sync(2);
    run(60, 20);

    // random settings, some runs with mid-run input changes (R6)
    for (int r = 0; r < 40; r++) begin
      hi_f = 4'($urandom);
      lo_f = 4'($urandom);
      for (int i = 0; i < 4; i++) begin
        ph[i] = 4'($urandom);
        st[i] = 1'($urandom);
      end
      do_sync(1 + int'($urandom % 3));
      run(90, (r % 2 == 0) ? 10 + int'($urandom % 40) : -1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule